// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block paces instruction execution in a small controller core whose program words are 16 bits wide. It divides the oscillator clock into instruction cycles of four clock periods each, and shows the current quarter on a one-hot phase bus. In each cycle it presents one fetch address to program memory and holds it stable. At the end of the cycle it moves the word read from that address into the execute slot and steps the address by one.

The execute stage reports three things back to the sequencer. It says when it has redirected the program counter, when a conditional skip has succeeded, and when the word it holds opens a two-word instruction. On a redirect or a taken skip, the sequencer replaces the prefetched word with a NOP slot. A redirect also loads the target into the fetch address. For a two-word opcode, the next slot carries the second word as an operand and not as an instruction. Any word whose top four bits are all ones is a trailing operand word. If such a word arrives in the slot as an instruction, for example after a skip lands on it, it becomes a NOP.

Each instruction therefore occupies a fixed number of cycles:

- a plain instruction takes one cycle;
- a taken skip or a one-word jump takes two cycles;
- a two-word instruction takes two cycles;
- a taken two-word jump takes three cycles.

Top module: `isq_sequencer`

## Requirements
- R1: `phase` is one-hot. It starts at bit 0 and moves up one bit per clock. After bit 3 it returns to bit 0, so one instruction cycle is four clocks and ends on the clock edge that leaves bit 3.
- R2: While `rst` is high and on the first clock after it falls, the outputs are: `phase` = 4'b0001, `fetch_addr` = 0, and the execute slot is a NOP (`ex_valid` = 0, `ex_operand` = 0). The whole first instruction cycle after reset is a NOP.
- R3: `fetch_addr` holds steady within a cycle. At a cycle end with no accepted redirect, it steps up by one.
- R4: At a cycle end with no redirect, no taken skip and no two-word opcode, `ex_word` takes the word read at the old `fetch_addr`. `ex_valid` goes high for the next cycle unless R9 applies, so a plain instruction spans one cycle.
- R5: `ex_pc_change` is accepted at a cycle end while the slot holds an instruction or an operand word. When accepted, `fetch_addr` loads `ex_target` and the next slot is a NOP, so a one-word jump spans two cycles.
- R6: `ex_skip` is accepted at a cycle end while `ex_valid` is high. When accepted, the next slot is a NOP and `fetch_addr` steps by one, so a taken skip spans two cycles.
- R7: `ex_two_word` is accepted at a cycle end while `ex_valid` is high and neither a redirect nor a skip is accepted. When accepted, the next slot has `ex_operand` = 1 and `ex_word` equal to the following program word, so a two-word instruction spans two cycles.
- R8: A redirect raised during the operand cycle of a two-word instruction loads the target and then gives one NOP slot, so the instruction spans three cycles.
- R9: A word whose bits [15:12] are 4'hF never enters the slot as an instruction; it enters as a NOP. A taken skip onto a two-word instruction therefore spans three cycles.
- R10: During a NOP slot, all three execute inputs have no effect. During an operand slot, `ex_skip` and `ex_two_word` have no effect. A redirect takes priority over a skip, and a skip takes priority over a two-word opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_word | input | 16 | Program memory word read at `fetch_addr` |
| ex_pc_change | input | 1 | Execute stage has redirected the program counter |
| ex_target | input | 12 | Redirect target address |
| ex_skip | input | 1 | Execute stage conditional skip succeeded |
| ex_two_word | input | 1 | Slot word opens a two-word instruction |
| fetch_addr | output | 12 | Program counter / fetch address |
| phase | output | 4 | One-hot quarter of the instruction cycle |
| ex_word | output | 16 | Word in the execute slot |
| ex_valid | output | 1 | Slot holds an instruction to execute |
| ex_operand | output | 1 | Slot holds the second word of a two-word instruction |

## Verification
The assertions check these rules on every clock:
- the phase ring keeps its rotation;
- the fetch address holds within a cycle, and at each boundary it either steps by one or loads the target;
- every accepted redirect or skip is followed by a NOP slot;
- an operand slot only ever follows an accepted two-word opcode;
- a word marked as a trailing word never shows up as a valid instruction.

Cycle counts per instruction type need whole instruction sequences, so only the bench scenarios can show them. These are the 1/2/2/3 spans and the three-cycle skip over a two-word instruction. The same holds for the proof that inputs injected during NOP and operand slots leave the program flow unchanged.

// File: rtl/isq_pkg.sv
package isq_pkg;

    // Width of the marker field at the top of a trailing operand word
    localparam int unsigned TAIL_BITS = 4;

    // Kind of word occupying the execute slot
    typedef enum logic [1:0] {
        SLOT_NOP  = 2'd0,
        SLOT_EXEC = 2'd1,
        SLOT_TAIL = 2'd2
    } slot_e;

    // Execute-stage feedback bundle
    typedef struct packed {
        logic change;
        logic skip;
        logic two;
    } exec_ctl_t;

    // Resolved decision taken at a cycle boundary
    typedef struct packed {
        logic branch;
        logic skip;
        logic two;
    } exec_take_t;

    // A word whose marker field is all ones is the second half of a
    // two-word instruction and cannot start one.
    function automatic logic tail_marked(input logic [TAIL_BITS-1:0] top);
        return &top;
    endfunction

endpackage

// File: rtl/isq_phase_ring.sv
module isq_phase_ring #(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PHASES-1:0] phase,
    output logic              cycle_end
);

    localparam logic [PHASES-1:0] FIRST = PHASES'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= FIRST;
        end else begin
            phase <= {phase[PHASES-2:0], phase[PHASES-1]};
        end
    end

    assign cycle_end = phase[PHASES-1];

endmodule

// File: rtl/isq_pc_unit.sv
module isq_pc_unit #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_next;

    always_comb begin
        pc_next = pc + STEP;
        if (load) begin
            pc_next = target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (advance) begin
            pc <= pc_next;
        end
    end

endmodule

// File: rtl/isq_exec_slot.sv
module isq_exec_slot
    import isq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [WORD_W-1:0] fetched,
    input  exec_ctl_t         ctl,
    output slot_e             kind,
    output logic [WORD_W-1:0] word,
    output logic              take_branch
);

    localparam int TOP = WORD_W - 1;

    exec_take_t take;
    slot_e      kind_next;
    logic       live;
    logic       is_exec;

    assign live    = (kind != SLOT_NOP);
    assign is_exec = (kind == SLOT_EXEC);

    // Priority: redirect, then skip, then two-word opcode
    always_comb begin
        take.branch = ctl.change & live;
        take.skip   = ctl.skip & is_exec & ~take.branch;
        take.two    = ctl.two & is_exec & ~take.branch & ~ctl.skip;
    end

    always_comb begin
        if (take.branch || take.skip) begin
            kind_next = SLOT_NOP;
        end else if (take.two) begin
            kind_next = SLOT_TAIL;
        end else if (tail_marked(fetched[TOP -: TAIL_BITS])) begin
            kind_next = SLOT_NOP;
        end else begin
            kind_next = SLOT_EXEC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind <= SLOT_NOP;
            word <= '0;
        end else if (advance) begin
            kind <= kind_next;
            word <= fetched;
        end
    end

    assign take_branch = take.branch;

endmodule

// File: rtl/isq_sequencer.sv
module isq_sequencer
    import isq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] prog_word,
    input  logic              ex_pc_change,
    input  logic [ADDR_W-1:0] ex_target,
    input  logic              ex_skip,
    input  logic              ex_two_word,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [PHASES-1:0] phase,
    output logic [WORD_W-1:0] ex_word,
    output logic              ex_valid,
    output logic              ex_operand
);

    logic      cycle_end;
    logic      take_branch;
    slot_e     kind;
    exec_ctl_t ctl;

    assign ctl = '{change: ex_pc_change, skip: ex_skip, two: ex_two_word};

    isq_phase_ring #(.PHASES(PHASES)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .cycle_end (cycle_end)
    );

    isq_exec_slot #(.WORD_W(WORD_W)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .advance     (cycle_end),
        .fetched     (prog_word),
        .ctl         (ctl),
        .kind        (kind),
        .word        (ex_word),
        .take_branch (take_branch)
    );

    isq_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .advance (cycle_end),
        .load    (take_branch),
        .target  (ex_target),
        .pc      (fetch_addr)
    );

    assign ex_valid   = (kind == SLOT_EXEC);
    assign ex_operand = (kind == SLOT_TAIL);

endmodule

// File: rtl/isq_sequencer_chk.sv
module isq_sequencer_chk #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    parameter int PHASES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ex_pc_change,
    input logic [ADDR_W-1:0] ex_target,
    input logic              ex_skip,
    input logic              ex_two_word,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [PHASES-1:0] phase,
    input logic [WORD_W-1:0] ex_word,
    input logic              ex_valid,
    input logic              ex_operand
);

    logic last_q;
    logic redirect;
    logic flush;

    assign last_q   = phase[PHASES-1];
    assign redirect = ex_pc_change && (ex_valid || ex_operand);
    assign flush    = redirect || (ex_skip && ex_valid);

    p_phase_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
        !last_q |=> phase == ($past(phase) << 1));

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        last_q |=> phase[0]);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !last_q |=> $stable(fetch_addr));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        last_q && !redirect |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

    p_slot_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !last_q |=> $stable({ex_valid, ex_operand, ex_word}));

    p_addr_load_r5: assert property (@(posedge clk) disable iff (rst)
        last_q && redirect |=> fetch_addr == $past(ex_target));

    p_flush_nop_r6: assert property (@(posedge clk) disable iff (rst)
        last_q && flush |=> !ex_valid && !ex_operand);

    p_tail_follows_r7: assert property (@(posedge clk) disable iff (rst)
        last_q && ex_valid && ex_two_word && !ex_pc_change && !ex_skip
        |=> ex_operand && !ex_valid);

    p_tail_origin_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ex_operand) |-> $past(ex_valid && ex_two_word));

    p_slot_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(ex_valid && ex_operand));

    p_stray_nop_r9: assert property (@(posedge clk) disable iff (rst)
        ex_valid |-> ex_word[WORD_W-1 -: 4] != 4'hF);

    p_nop_inert_r10: assert property (@(posedge clk) disable iff (rst)
        last_q && !ex_valid && !ex_operand
        |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1) && !ex_operand);

endmodule

bind isq_sequencer isq_sequencer_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .PHASES (PHASES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ex_pc_change (ex_pc_change),
    .ex_target    (ex_target),
    .ex_skip      (ex_skip),
    .ex_two_word  (ex_two_word),
    .fetch_addr   (fetch_addr),
    .phase        (phase),
    .ex_word      (ex_word),
    .ex_valid     (ex_valid),
    .ex_operand   (ex_operand)
);

// File: tb/tb_isq_sequencer.sv
module tb_isq_sequencer;

    localparam int AW = 12;
    localparam int WW = 16;
    localparam int PH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WW-1:0] prog_word;
    logic          ex_pc_change;
    logic [AW-1:0] ex_target;
    logic          ex_skip;
    logic          ex_two_word;
    logic [AW-1:0] fetch_addr;
    logic [PH-1:0] phase;
    logic [WW-1:0] ex_word;
    logic          ex_valid;
    logic          ex_operand;

    // Program store and bench-side execute stage
    logic [15:0] mem [64];
    logic [15:0] first_word = '0;
    logic        inject = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    int          ep;
    int          m_kind;
    logic [15:0] m_word;
    logic [15:0] m_first;
    logic [11:0] m_pc;
    logic [11:0] m_addr;
    bit          span_on;
    bit          have_prev;
    int          span;
    logic [11:0] prev_addr;
    bit          inj_nop_prev;
    bit          inj_on;

    always #10 clk = ~clk;

    isq_sequencer #(.ADDR_W(AW), .WORD_W(WW), .PHASES(PH)) dut (
        .clk          (clk),
        .rst          (rst),
        .prog_word    (prog_word),
        .ex_pc_change (ex_pc_change),
        .ex_target    (ex_target),
        .ex_skip      (ex_skip),
        .ex_two_word  (ex_two_word),
        .fetch_addr   (fetch_addr),
        .phase        (phase),
        .ex_word      (ex_word),
        .ex_valid     (ex_valid),
        .ex_operand   (ex_operand)
    );

    // Bench decode: C=jump to low 6 bits, B=skip if bit0, E=two-word
    // (bit 11 set: jump to low 6 bits of the second word)
    always_comb begin
        prog_word    = mem[fetch_addr[5:0]];
        ex_target    = {6'b0, ex_word[5:0]};
        ex_pc_change = (ex_valid && ex_word[15:12] == 4'hC)
                     || (ex_operand && first_word[11])
                     || (inject && !ex_valid && !ex_operand);
        ex_skip      = (ex_valid && ex_word[15:12] == 4'hB && ex_word[0])
                     || (inject && !ex_valid);
        ex_two_word  = (ex_valid && ex_word[15:12] == 4'hE)
                     || (inject && !ex_valid);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int dir_span(input logic [11:0] a);
        case (a)
            12'd1, 12'd4, 12'd10, 12'd24: return 2;
            12'd6, 12'd20:                return 3;
            default:                      return 1;
        endcase
    endfunction

    function automatic string dir_req(input logic [11:0] a);
        case (a)
            12'd1:         return "R6";
            12'd4:         return "R7";
            12'd6:         return "R8";
            12'd10, 12'd24: return "R5";
            12'd20:        return "R9";
            default:       return "R4";
        endcase
    endfunction

    task automatic model_step();
        bit          v, o, chg, skp, two;
        logic [15:0] fw;
        v   = (m_kind == 1);
        o   = (m_kind == 2);
        chg = (v && m_word[15:12] == 4'hC) || (o && m_first[11]);
        skp = v && m_word[15:12] == 4'hB && m_word[0];
        two = v && m_word[15:12] == 4'hE;
        fw  = mem[m_pc[5:0]];
        if (v) m_first = m_word;
        if (chg) begin
            m_pc   = {6'b0, m_word[5:0]};
            m_kind = 0;
        end else begin
            if (skp) begin
                m_kind = 0;
            end else if (two) begin
                m_kind = 2;
                m_word = fw;
            end else begin
                m_word = fw;
                m_kind = (fw[15:12] == 4'hF) ? 0 : 1;
                m_addr = m_pc;
            end
            m_pc = m_pc + 12'd1;
        end
    endtask

    // Called at a falling edge; compares, advances the model, waits one clock
    task automatic tick();
        string rq;
        if (ep == 0) begin
            inject = inj_on && ($urandom % 3 == 0);
        end
        check(phase == PH'(1 << ep), "R1", "phase", 32'(phase), 32'(1 << ep));
        rq = inj_nop_prev ? "R10" : "R3";
        check(fetch_addr == m_pc, rq, "fetch_addr", 32'(fetch_addr), 32'(m_pc));
        if (ep == 3) begin
            check(ex_valid == (m_kind == 1), inj_nop_prev ? "R10" : "R4",
                  "ex_valid", 32'(ex_valid), 32'(m_kind == 1));
            check(ex_operand == (m_kind == 2), "R7", "ex_operand",
                  32'(ex_operand), 32'(m_kind == 2));
            if (m_kind != 0)
                check(ex_word == m_word, "R4", "ex_word", 32'(ex_word), 32'(m_word));
            if (span_on) begin
                if (m_kind == 1) begin
                    if (have_prev)
                        check(span == dir_span(prev_addr), dir_req(prev_addr),
                              "cycles per instruction", 32'(span),
                              32'(dir_span(prev_addr)));
                    have_prev = 1;
                    prev_addr = m_addr;
                    span      = 1;
                end else begin
                    span++;
                end
            end
            if (ex_valid) first_word = ex_word;
            inj_nop_prev = inject && (m_kind != 1);
            model_step();
        end
        ep = (ep + 1) % 4;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        inject = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(phase == 4'b0001 && fetch_addr == '0 && !ex_valid && !ex_operand,
              "R2", "state during reset",
              {15'b0, ex_valid, ex_operand, phase, fetch_addr}, 32'h0001000);
        rst = 1'b0;
        check(phase == 4'b0001, "R2", "phase after reset", 32'(phase), 32'h1);
        check(fetch_addr == '0, "R2", "fetch_addr after reset", 32'(fetch_addr), 0);
        check(!ex_valid && !ex_operand, "R2", "slot after reset",
              {30'b0, ex_valid, ex_operand}, 0);
        ep = 0; m_kind = 0; m_word = '0; m_first = '0; m_pc = '0; m_addr = '0;
        first_word = '0; have_prev = 0; span = 0; inj_nop_prev = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        // Directed program
        mem[0]  = 16'h1111;  // plain
        mem[1]  = 16'hB001;  // skip taken
        mem[2]  = 16'h2222;
        mem[3]  = 16'hB000;  // skip not taken
        mem[4]  = 16'hE000;  // two-word
        mem[5]  = 16'hF055;
        mem[6]  = 16'hE800;  // two-word jump
        mem[7]  = 16'hF00A;  // -> 10
        mem[8]  = 16'h7777;
        mem[9]  = 16'h7777;
        mem[10] = 16'hC014;  // jump -> 20
        mem[11] = 16'h5555;
        mem[20] = 16'hB001;  // skip onto two-word
        mem[21] = 16'hE000;
        mem[22] = 16'hF0AA;  // stray tail word
        mem[23] = 16'h3333;
        mem[24] = 16'hC000;  // jump -> 0
        inj_on  = 0;
        span_on = 1;
        do_reset();
        for (int n = 0; n < 60 * 4; n++) tick();

        // Random programs with injected inputs during NOP/operand slots
        span_on = 0;
        inj_on  = 1;
        for (int i = 0; i < 64; i++) begin
            case ($urandom % 7)
                0, 1:    mem[i] = {1'b0, 15'($urandom)};
                2:       mem[i] = {4'hB, 11'($urandom), 1'($urandom)};
                3:       mem[i] = {4'hC, 6'($urandom), 6'($urandom)};
                4:       mem[i] = {4'hE, 12'($urandom)};
                5:       mem[i] = {4'hF, 12'($urandom)};
                default: mem[i] = {4'h9, 12'($urandom)};
            endcase
        end
        do_reset();
        for (int n = 0; n < 600 * 4; n++) tick();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule